// File: doc/BRIEF.md
# Self-Synchronizing PRBS Error Checker

This block checks a sampled serial bit stream, presented one bit per clock with a valid strobe, against a locally generated maximal-length pseudo-random sequence of a selectable order. The transmitting side must use the same pattern order. The checker has no fixed seed. While its enable input is low it trains: it loads its generator from the bits it has just received, predicts each next bit, and declares lock once a long enough run of predictions has matched.

When enable is high and no retraining is pending, the generator runs freely from its trained state. Every compared bit increments a compared-bit counter, and every mismatch increments an error counter. Both counters saturate, and they hold their values while enable is low. The ratio of the two counters gives the bit error rate. If lock was never reached, the block still counts, and the ratio comes out close to one half instead of the block stalling.

Top module: `prbs_lock_checker`

## Requirements
- R1: `order_sel` picks the pattern order: code 0 selects 7 with tap 6, 1 selects 10/7, 2 selects 15/14, 3 selects 23/18, and 4 as well as the unused codes 5 to 7 select 31/28. Each bit of the sequence is b[t] = b[t-tap] xor b[t-order].
- R2: In training, a valid bit that differs from the prediction reloads the generator from the last received bits and clears `locked`. `locked` rises on the 64th consecutive matching valid bit, so it is never set fewer than 64 valid bits after a reset or an order change. On a clean stream it is always set within order+64 valid bits.
- R3: A generator state that is all zero over the selected order never advances the lock run, so a constant-zero input never locks.
- R4: In counting mode the generator advances on its own prediction. Each valid bit adds one to `bit_count`, and each mismatching bit adds one to `err_count`, so an isolated corrupted bit costs exactly one error.
- R5: A cycle with `bit_valid` low neither advances the generator nor changes either counter.
- R6: Both counters stop at 2^CNT_W-1 and never wrap.
- R7: While `enable` is low, both counters hold their values. Training continues, and `locked` remains set on a stream that still matches.
- R8: A reset or a change of `order_sel` clears `locked` and both counters and forces retraining. If `enable` is high at that moment, counting is held off (`counting` low) until lock is reached. A bit presented in the cycle of an order change is discarded.
- R9: Once `enable` has been low after a reset or an order change, raising it starts counting even if lock was never reached. On an uncorrelated stream, `err_count` then comes out at about half of `bit_count`.
- R10: `err_count` never exceeds `bit_count`.
- R11: When `enable` rises with no retraining pending, the next valid bit is counted, with no added delay cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| order_sel | input | 3 | Pattern order code (see R1) |
| enable | input | 1 | High: count errors; low: train |
| bit_valid | input | 1 | `bit_in` holds a sampled bit this cycle |
| bit_in | input | 1 | Sampled serial data bit |
| locked | output | 1 | Generator aligned to the incoming stream |
| counting | output | 1 | Valid bits are being counted this cycle |
| err_count | output | CNT_W | Saturating count of mismatching bits |
| bit_count | output | CNT_W | Saturating count of compared bits |

## Verification
The assertions check on every cycle the properties that follow from the counter ports alone:
- the counters step by at most one, hold on idle or disabled cycles, and stick at their maximum;
- `err_count` never passes `bit_count`;
- reset clears everything;
- lock only rises after a valid bit.

The scenarios have to show the rest, because those behaviours depend on the pattern content:
- the exact lock window for every order, including the alias codes;
- one error for each isolated flipped bit;
- the hold-off after an order change under enable;
- the near-half error rate of an unlocked checker;
- an all-zero stream never locking.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int MAX_ORDER = 31;

    typedef logic [2:0] order_code_t;

    function automatic logic [4:0] order_len(input order_code_t code);
        case (code)
            3'd0:    return 5'd7;
            3'd1:    return 5'd10;
            3'd2:    return 5'd15;
            3'd3:    return 5'd23;
            default: return 5'd31;
        endcase
    endfunction

    function automatic logic [4:0] order_tap(input order_code_t code);
        case (code)
            3'd0:    return 5'd6;
            3'd1:    return 5'd7;
            3'd2:    return 5'd14;
            3'd3:    return 5'd18;
            default: return 5'd28;
        endcase
    endfunction

endpackage

// File: rtl/prbs_feedback.sv
module prbs_feedback
    import prbs_chk_pkg::*;
#(
    parameter int W = MAX_ORDER
) (
    input  logic [W-1:0] state,
    input  order_code_t  order_code,
    output logic         predict,
    output logic         live
);
    logic [4:0]   len;
    logic [4:0]   tap;
    logic [W-1:0] used_bits;

    always_comb begin
        len = order_len(order_code);
        tap = order_tap(order_code);
    end

    // Keep only the state bits that belong to the selected order.
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign used_bits[i] = state[i] & (5'(i) < len);
    end

    assign predict = state[tap - 5'd1] ^ state[len - 5'd1];
    assign live    = |used_bits;

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (inc && cnt_q != TOP) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/prbs_lock_checker.sv
module prbs_lock_checker
    import prbs_chk_pkg::*;
#(
    parameter int CNT_W    = 48,
    parameter int LOCK_RUN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       order_sel,
    input  logic             enable,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic             locked,
    output logic             counting,
    output logic [CNT_W-1:0] err_count,
    output logic [CNT_W-1:0] bit_count
);
    localparam int SW    = MAX_ORDER;
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_DONE = RUN_W'(LOCK_RUN);

    typedef struct packed {
        logic [SW-1:0]    hist;
        logic [SW-1:0]    gen;
        logic [RUN_W-1:0] run;
        logic             locked;
        logic             retrain;
        order_code_t      order;
    } core_t;

    core_t         cur_q;
    core_t         nxt_d;
    logic          pred;
    logic          gen_live;
    logic          mism;
    logic          order_chg;
    logic          count_mode;
    logic          inc_bits;
    logic          inc_errs;
    logic [SW-1:0] hist_shift;

    prbs_feedback #(.W(SW)) u_fb (
        .state      (cur_q.gen),
        .order_code (cur_q.order),
        .predict    (pred),
        .live       (gen_live)
    );

    always_comb begin
        nxt_d      = cur_q;
        inc_bits   = 1'b0;
        inc_errs   = 1'b0;
        order_chg  = (order_sel != cur_q.order);
        count_mode = enable && !cur_q.retrain;
        hist_shift = {cur_q.hist[SW-2:0], bit_in};
        mism       = bit_in ^ pred;
        nxt_d.order = order_sel;

        if (!enable) begin
            nxt_d.retrain = 1'b0;
        end

        if (order_chg) begin
            nxt_d.locked  = 1'b0;
            nxt_d.run     = '0;
            nxt_d.retrain = 1'b1;
        end else if (bit_valid) begin
            nxt_d.hist = hist_shift;
            if (count_mode) begin
                nxt_d.gen = {cur_q.gen[SW-2:0], pred};
                inc_bits  = 1'b1;
                inc_errs  = mism;
            end else if (mism) begin
                nxt_d.gen    = hist_shift;
                nxt_d.run    = '0;
                nxt_d.locked = 1'b0;
            end else begin
                nxt_d.gen = {cur_q.gen[SW-2:0], bit_in};
                if (gen_live && cur_q.run != RUN_DONE) begin
                    nxt_d.run = cur_q.run + RUN_W'(1);
                    if (cur_q.run + RUN_W'(1) == RUN_DONE) begin
                        nxt_d.locked  = 1'b1;
                        nxt_d.retrain = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q         <= '0;
            cur_q.retrain <= 1'b1;
            cur_q.order   <= order_sel;
        end else begin
            cur_q <= nxt_d;
        end
    end

    sat_counter #(.W(CNT_W)) u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (order_chg),
        .inc   (inc_bits),
        .count (bit_count)
    );

    sat_counter #(.W(CNT_W)) u_errs (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (order_chg),
        .inc   (inc_errs),
        .count (err_count)
    );

    assign locked   = cur_q.locked;
    assign counting = count_mode;

endmodule

// File: rtl/prbs_lock_checker_sva.sv
module prbs_lock_checker_sva #(
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       order_sel,
    input logic             enable,
    input logic             bit_valid,
    input logic             locked,
    input logic [CNT_W-1:0] err_count,
    input logic [CNT_W-1:0] bit_count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> (!locked && err_count == '0 && bit_count == '0));

    assert_err_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_count <= bit_count);

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bit_count == $past(bit_count) || bit_count == $past(bit_count) + 1'b1
                  || bit_count == '0));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> ($stable(bit_count) && $stable(err_count)) || bit_count == '0);

    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $stable(order_sel)) |=> ($stable(bit_count) && $stable(err_count)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_count == TOP && $stable(order_sel)) |=> bit_count == TOP);

    assert_err_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == TOP && $stable(order_sel)) |=> err_count == TOP);

    assert_lock_on_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(bit_valid));

endmodule

bind prbs_lock_checker prbs_lock_checker_sva #(.CNT_W(CNT_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .order_sel (order_sel),
    .enable    (enable),
    .bit_valid (bit_valid),
    .locked    (locked),
    .err_count (err_count),
    .bit_count (bit_count)
);

// File: tb/prbs_lock_checker_test.sv
`timescale 1ns/1ps
module prbs_lock_checker_test;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    order_sel = 3'd0;
    logic          enable = 1'b0;
    logic          bit_valid = 1'b0;
    logic          bit_in = 1'b0;
    logic          locked;
    logic          counting;
    logic [CW-1:0] err_count;
    logic [CW-1:0] bit_count;

    int            n_run = 0;
    int            n_fail = 0;
    logic [30:0]   bh = '1;
    int            bn = 7;
    int            bk = 6;
    int unsigned   lcg = 32'h1234_5678;

    always #10 clk = ~clk;

    prbs_lock_checker #(.CNT_W(CW), .LOCK_RUN(64)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .order_sel (order_sel),
        .enable    (enable),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .locked    (locked),
        .counting  (counting),
        .err_count (err_count),
        .bit_count (bit_count)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic b, input logic v);
        bit_in    = b;
        bit_valid = v;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic set_taps(input logic [2:0] code);
        case (code)
            3'd0: begin bn = 7;  bk = 6;  end
            3'd1: begin bn = 10; bk = 7;  end
            3'd2: begin bn = 15; bk = 14; end
            3'd3: begin bn = 23; bk = 18; end
            default: begin bn = 31; bk = 28; end
        endcase
        bh = '1;
    endtask

    task automatic next_bit(output logic b);
        b  = bh[bk-1] ^ bh[bn-1];
        bh = {bh[29:0], b};
    endtask

    task automatic send(input int cnt, input bit gaps, input int flip_every);
        logic b;
        for (int i = 0; i < cnt; i++) begin
            if (gaps && (i % 3) == 1) push(1'b1, 1'b0);
            next_bit(b);
            if (flip_every > 0 && (i % flip_every) == flip_every - 1) b = ~b;
            push(b, 1'b1);
        end
    endtask

    task automatic change_order(input logic [2:0] code);
        order_sel = code;
        push(1'b0, 1'b0);
        set_taps(code);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int bc;
        @(negedge clk);
        repeat (3) push(1'b0, 1'b0);
        chk("R8 reset locked", locked, 0);
        chk("R8 reset bits", bit_count, 0);
        chk("R8 reset errs", err_count, 0);
        rst_n = 1'b1;
        push(1'b0, 1'b0);

        // Every order: lock window, counting, gaps, freeze, immediate start
        for (int c = 0; c < 5; c++) begin
            enable = 1'b0;
            change_order(3'(c + 1 == 5 ? 4 : c + 1));
            change_order(3'(c));
            chk("R8 change clears bits", bit_count, 0);
            send(63, 1'b0, 0);
            chk("R2 not locked before 64", locked, 0);
            send(bn + 1, 1'b0, 0);
            chk("R2 locked within order+64", locked, 1);
            chk("R7 frozen in training", bit_count, 0);
            enable = 1'b1;
            send(40, 1'b1, 0);
            chk("R5 R1 clean with gaps errs", err_count, 0);
            chk("R5 bits with gaps", bit_count, 40);
            send(20, 1'b0, 5);
            chk("R4 single flips errs", err_count, 4);
            chk("R4 bits", bit_count, 60);
            enable = 1'b0;
            send(10, 1'b0, 0);
            chk("R7 frozen bits", bit_count, 60);
            chk("R7 frozen errs", err_count, 4);
            chk("R7 lock held", locked, 1);
            enable = 1'b1;
            send(1, 1'b0, 0);
            chk("R11 immediate count", bit_count, 61);
        end

        // Alias code 7 behaves as order 31, then saturation
        enable = 1'b0;
        change_order(3'd7);
        send(63, 1'b0, 0);
        chk("R1 alias not locked early", locked, 0);
        send(32, 1'b0, 0);
        chk("R1 alias locks as 31", locked, 1);
        enable = 1'b1;
        send(250, 1'b0, 1);
        chk("R6 bits below top", bit_count, 250);
        chk("R6 errs below top", err_count, 250);
        send(10, 1'b0, 1);
        chk("R6 bits saturate", bit_count, 255);
        chk("R6 errs saturate", err_count, 255);

        // Never locked: counts still run near one half
        enable = 1'b0;
        change_order(3'd0);
        for (int i = 0; i < 30; i++) begin
            lcg = lcg * 1103515245 + 12345;
            push(lcg[16], 1'b1);
        end
        enable = 1'b1;
        for (int i = 0; i < 200; i++) begin
            lcg = lcg * 1103515245 + 12345;
            push(lcg[16], 1'b1);
        end
        chk("R9 unlocked bits", bit_count, 200);
        chk("R9 unlocked", locked, 0);
        chk("R9 errs near half", (err_count > 50 && err_count < 150) ? 1 : 0, 1);
        chk("R10 errs within bits", (err_count <= bit_count) ? 1 : 0, 1);

        // Order change under enable holds counting until lock
        change_order(3'd1);
        chk("R8 change clears errs", err_count, 0);
        chk("R8 change clears lock", locked, 0);
        chk("R8 hold-off", counting, 0);
        send(63, 1'b0, 0);
        chk("R8 no count while retraining", bit_count, 0);
        send(bn + 1, 1'b0, 0);
        chk("R8 relocked", locked, 1);
        chk("R8 counting resumes", counting, 1);
        bc = int'(bit_count);
        send(10, 1'b0, 0);
        chk("R8 counts after relock", bit_count, bc + 10);
        chk("R8 clean after relock", err_count, 0);

        // Reset mid-run
        rst_n = 1'b0;
        push(1'b0, 1'b0);
        push(1'b0, 1'b0);
        chk("R8 reset clears bits", bit_count, 0);
        chk("R8 reset clears lock", locked, 0);
        rst_n = 1'b1;
        enable = 1'b0;

        // Constant zero never locks
        change_order(3'd2);
        for (int i = 0; i < 150; i++) push(1'b0, 1'b1);
        chk("R3 zero stream unlocked", locked, 0);
        chk("R3 zero stream no count", bit_count, 0);

        finish_run();
    end

endmodule